// File: doc/BRIEF.md
# Three-Mode Local Interrupt Timer

A per-core interrupt timer driven from a simple register bus. It runs in one of three modes. In one-shot mode a loaded count runs down once and raises an interrupt when it reaches zero. In periodic mode the count runs down repeatedly, reloading from the initial count each time. In deadline mode the timer compares a 64-bit free-running timestamp input against an armed deadline value. A divide field scales the countdown rate. A mask bit silences the interrupt output while the timer keeps running.

The count registers and the deadline register lock each other out. While the timer is in deadline mode, the count registers read zero and ignore writes. Outside deadline mode, the deadline register reads zero and ignores writes. Every mode change into or out of deadline mode clears the state that belongs to the mode being left. The interrupt output is a registered pulse, one cycle long per expiry.

Top module: `lapic_tmr_top`

## Requirements
- R1: After reset the control word reads 0x10000: mask set, mode one-shot, divide 0, vector 0. Both count registers and the deadline register read zero, and the interrupt output is low.
- R2: The control word sits at offset 0x320 and reads back as written. Its fields are: vector in bits 7:0, mask in bit 16, mode in bits 18:17 (00 one-shot, 01 periodic, 10 deadline), and the divide exponent in bits 21:19. A write with mode code 11 leaves the mode unchanged but updates the other fields.
- R3: In one-shot mode, a nonzero write N to the initial count (offset 0x380) makes the current count (offset 0x390) read N. The current count then falls by one per tick. With divide 0 the interrupt is high exactly in the N-th cycle after the write and never again, and the current count stays at zero.
- R4: In periodic mode, each time the count reaches zero the interrupt pulses and the current count reloads from the initial count. Successive pulses are exactly N·2^D cycles apart.
- R5: With divide field D, the countdown ticks once every 2^D clock cycles.
- R6: Writing an initial count of zero stops the countdown. The current count reads zero and no interrupt follows.
- R7: Outside deadline mode, writes to the deadline register (offset 0x3E0) are ignored and it reads zero.
- R8: Entering deadline mode clears both count registers to zero. While in deadline mode, initial-count writes are ignored and both count registers keep reading zero.
- R9: In deadline mode a nonzero deadline write arms the timer and reads back the written value. Once the timestamp is greater than or equal to the armed deadline, the interrupt pulses in the following cycle and the deadline reads zero. A deadline already in the past fires one cycle after it is written.
- R10: Writing a deadline of zero disarms the timer without raising an interrupt.
- R11: Leaving deadline mode clears the deadline register, and re-entering deadline mode does not restore it.
- R12: With the mask set, the interrupt output stays low. The countdown still runs to zero and the deadline comparison still consumes the armed deadline.
- R13: Switching between one-shot and periodic mode keeps the current count and carries on counting from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | TS_W | Write data |
| bus_rdata | output | TS_W | Read data for bus_addr (combinational) |
| tstamp | input | TS_W | Free-running timestamp |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The hardest state to reach is a periodic interval measured under every divide setting. The first expiry depends on the free-running prescaler phase, so its timing cannot be predicted from the ports. The stimulus therefore sweeps small counts against divide exponents 0 to 3 and records the cycle numbers of three consecutive pulses. It checks only the gaps between them, which a correct design fixes at N·2^D. The deadline interlocks are reached by stepping the timestamp by hand across the armed value, including across mask changes and across mode changes into and out of deadline mode.

// File: rtl/lapic_tmr_pkg.sv
package lapic_tmr_pkg;
   typedef enum logic [1:0] {
      TM_ONESHOT  = 2'b00,
      TM_PERIODIC = 2'b01,
      TM_DEADLINE = 2'b10,
      TM_RSVD     = 2'b11
   } tmr_mode_e;

   localparam logic [11:0] OFS_CTRL = 12'h320;
   localparam logic [11:0] OFS_INIT = 12'h380;
   localparam logic [11:0] OFS_CUR  = 12'h390;
   localparam logic [11:0] OFS_DL   = 12'h3E0;

   localparam int MASK_BIT = 16;
   localparam int MODE_LSB = 17;
   localparam int DIV_LSB  = 19;
endpackage

// File: rtl/lapic_tmr_ctrl.sv
module lapic_tmr_ctrl
   import lapic_tmr_pkg::*;
#(
   parameter int VEC_W = 8,
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [VEC_W-1:0] wd_vec,
   input  logic             wd_mask,
   input  logic [1:0]       wd_mode,
   input  logic [DIV_W-1:0] wd_div,
   output tmr_mode_e        mode_o,
   output logic             mask_o,
   output logic [DIV_W-1:0] div_o,
   output logic [31:0]      ctrl_rd_o,
   output logic             enter_dl_o,
   output logic             leave_dl_o
);
   logic [VEC_W-1:0] vec_q;
   logic             mask_q;
   tmr_mode_e        mode_q;
   logic [DIV_W-1:0] div_q;
   tmr_mode_e        req_mode;
   tmr_mode_e        nxt_mode;

   generate
      if (VEC_W < 1 || VEC_W > MASK_BIT) begin : g_bad_vec
         $error("lapic_tmr_ctrl: VEC_W must be 1..16");
      end
      if (DIV_W < 1 || DIV_W + DIV_LSB > 32) begin : g_bad_div
         $error("lapic_tmr_ctrl: DIV_W out of range");
      end
   endgenerate

   always_comb begin
      req_mode   = tmr_mode_e'(wd_mode);
      nxt_mode   = (req_mode == TM_RSVD) ? mode_q : req_mode;
      enter_dl_o = wr_en && (nxt_mode == TM_DEADLINE) && (mode_q != TM_DEADLINE);
      leave_dl_o = wr_en && (mode_q == TM_DEADLINE) && (nxt_mode != TM_DEADLINE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q  <= '0;
         mask_q <= 1'b1;
         mode_q <= TM_ONESHOT;
         div_q  <= '0;
      end else if (wr_en) begin
         vec_q  <= wd_vec;
         mask_q <= wd_mask;
         mode_q <= nxt_mode;
         div_q  <= wd_div;
      end
   end

   always_comb begin
      ctrl_rd_o                            = '0;
      ctrl_rd_o[VEC_W-1:0]                 = vec_q;
      ctrl_rd_o[MASK_BIT]                  = mask_q;
      ctrl_rd_o[MODE_LSB +: 2]             = mode_q;
      ctrl_rd_o[DIV_LSB +: DIV_W]          = div_q;
   end

   assign mode_o = mode_q;
   assign mask_o = mask_q;
   assign div_o  = div_q;

   AST_NO_RSVD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q != TM_RSVD);                                                    // R2
endmodule

// File: rtl/lapic_tmr_presc.sv
module lapic_tmr_presc #(
   parameter int DIV_W   = 3,
   parameter bit USE_DIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int PS_W = (1 << DIV_W) - 1;

   generate
      if (USE_DIV) begin : g_div
         logic [PS_W-1:0] ps_q;
         logic [PS_W-1:0] ps_mask;

         always_ff @(posedge clk) begin
            if (!rst_n) ps_q <= '0;
            else        ps_q <= ps_q + 1'b1;
         end

         always_comb begin
            ps_mask = ~({PS_W{1'b1}} << div);
            tick    = (ps_q & ps_mask) == ps_mask;
         end

         AST_TICK_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
            (div == '0) |-> tick);                                           // R5
         AST_TICK_SPARSE: assert property (@(posedge clk) disable iff (!rst_n)
            (div != '0) && tick && $stable(div) |=> !tick);                  // R5
      end else begin : g_nodiv
         logic unused_div;
         assign unused_div = ^{div, clk, rst_n};
         assign tick       = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/lapic_tmr_count.sv
module lapic_tmr_count
   import lapic_tmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  tmr_mode_e        mode,
   input  logic             init_wr,
   input  logic [CNT_W-1:0] init_wd,
   input  logic             clear,
   output logic [CNT_W-1:0] init_o,
   output logic [CNT_W-1:0] cur_o,
   output logic             fire_o
);
   logic [CNT_W-1:0] init_q;
   logic [CNT_W-1:0] cur_q;
   logic             load;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("lapic_tmr_count: CNT_W must be at least 2");
      end
   endgenerate

   always_comb begin
      load   = init_wr && (mode != TM_DEADLINE);
      fire_o = tick && (cur_q == CNT_W'(1)) && !load && !clear;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_q <= '0;
         cur_q  <= '0;
      end else if (clear) begin
         init_q <= '0;
         cur_q  <= '0;
      end else if (load) begin
         init_q <= init_wd;
         cur_q  <= init_wd;
      end else if (tick && (cur_q != '0)) begin
         if (cur_q == CNT_W'(1))
            cur_q <= (mode == TM_PERIODIC) ? init_q : '0;
         else
            cur_q <= cur_q - 1'b1;
      end
   end

   assign init_o = init_q;
   assign cur_o  = cur_q;

   AST_CNT_IDLE_IN_DL: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_DEADLINE) |-> (init_q == '0) && (cur_q == '0));            // R8
   AST_ONESHOT_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == '0) && !init_wr |=> (cur_q == '0));                          // R3
   AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o && (mode == TM_PERIODIC) |=> (cur_q == $past(init_q)));         // R4
   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !init_wr && !clear |=> $stable(cur_q));                       // R5
endmodule

// File: rtl/lapic_tmr_dline.sv
module lapic_tmr_dline
   import lapic_tmr_pkg::*;
#(
   parameter int TS_W = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  tmr_mode_e       mode,
   input  logic            dl_wr,
   input  logic [TS_W-1:0] dl_wd,
   input  logic [TS_W-1:0] tstamp,
   input  logic            clear,
   output logic [TS_W-1:0] dl_o,
   output logic            fire_o
);
   logic [TS_W-1:0] dl_q;
   logic            accept;

   always_comb begin
      accept = dl_wr && (mode == TM_DEADLINE);
      fire_o = (dl_q != '0) && (tstamp >= dl_q) && !accept && !clear;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       dl_q <= '0;
      else if (clear)   dl_q <= '0;
      else if (accept)  dl_q <= dl_wd;
      else if (fire_o)  dl_q <= '0;
   end

   assign dl_o = dl_q;

   AST_DL_IDLE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != TM_DEADLINE) |-> (dl_q == '0));                               // R7
   AST_DL_CLEAR_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> (dl_q == '0));                                              // R9
   AST_DL_HOLD_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      (dl_q != '0) && (tstamp < dl_q) && !dl_wr && !clear |=> $stable(dl_q)); // R9
endmodule

// File: rtl/lapic_tmr_top.sv
module lapic_tmr_top
   import lapic_tmr_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int TS_W    = 64,
   parameter int CNT_W   = 32,
   parameter int VEC_W   = 8,
   parameter int DIV_W   = 3,
   parameter bit USE_DIV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [TS_W-1:0]   bus_wdata,
   output logic [TS_W-1:0]   bus_rdata,
   input  logic [TS_W-1:0]   tstamp,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(OFS_INIT);
   localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(OFS_CUR);
   localparam logic [ADDR_W-1:0] A_DL   = ADDR_W'(OFS_DL);

   generate
      if (ADDR_W < 12) begin : g_bad_addr
         $error("lapic_tmr_top: ADDR_W must be at least 12");
      end
      if (TS_W < 32 || CNT_W > TS_W) begin : g_bad_ts
         $error("lapic_tmr_top: need TS_W >= 32 and CNT_W <= TS_W");
      end
   endgenerate

   logic             wr_ctrl, wr_init, wr_dl;
   tmr_mode_e        mode;
   logic             mask;
   logic [DIV_W-1:0] div;
   logic [31:0]      ctrl_rd;
   logic             enter_dl, leave_dl;
   logic             tick;
   logic [CNT_W-1:0] init_v, cur_v;
   logic             cd_fire;
   logic [TS_W-1:0]  dl_v;
   logic             dl_fire;
   logic             irq_q;

   always_comb begin
      wr_ctrl = bus_sel && bus_we && (bus_addr == A_CTRL);
      wr_init = bus_sel && bus_we && (bus_addr == A_INIT);
      wr_dl   = bus_sel && bus_we && (bus_addr == A_DL);
   end

   lapic_tmr_ctrl #(.VEC_W(VEC_W), .DIV_W(DIV_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_ctrl),
      .wd_vec     (bus_wdata[VEC_W-1:0]),
      .wd_mask    (bus_wdata[MASK_BIT]),
      .wd_mode    (bus_wdata[MODE_LSB +: 2]),
      .wd_div     (bus_wdata[DIV_LSB +: DIV_W]),
      .mode_o     (mode),
      .mask_o     (mask),
      .div_o      (div),
      .ctrl_rd_o  (ctrl_rd),
      .enter_dl_o (enter_dl),
      .leave_dl_o (leave_dl)
   );

   lapic_tmr_presc #(.DIV_W(DIV_W), .USE_DIV(USE_DIV)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .div   (div),
      .tick  (tick)
   );

   lapic_tmr_count #(.CNT_W(CNT_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .mode    (mode),
      .init_wr (wr_init),
      .init_wd (bus_wdata[CNT_W-1:0]),
      .clear   (enter_dl),
      .init_o  (init_v),
      .cur_o   (cur_v),
      .fire_o  (cd_fire)
   );

   lapic_tmr_dline #(.TS_W(TS_W)) u_dline (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (mode),
      .dl_wr  (wr_dl),
      .dl_wd  (bus_wdata),
      .tstamp (tstamp),
      .clear  (leave_dl),
      .dl_o   (dl_v),
      .fire_o (dl_fire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= (cd_fire || dl_fire) && !mask;
   end
   assign irq = irq_q;

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_CTRL:  bus_rdata[31:0]      = ctrl_rd;
         A_INIT:  bus_rdata[CNT_W-1:0] = init_v;
         A_CUR:   bus_rdata[CNT_W-1:0] = cur_v;
         A_DL:    bus_rdata            = dl_v;
         default: bus_rdata            = '0;
      endcase
   end

   AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
      mask |=> !irq_q);                                                      // R12
   AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !cd_fire && !dl_fire |=> !irq_q);                                      // R3
   AST_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !(cd_fire && dl_fire));                                                // R8
endmodule

// File: tb/lapic_tmr_top_tb.sv
module lapic_tmr_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [63:0] bus_wdata = '0;
   logic [63:0] bus_rdata;
   logic [63:0] tstamp = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [11:0] A_CTRL = 12'h320;
   localparam logic [11:0] A_INIT = 12'h380;
   localparam logic [11:0] A_CUR  = 12'h390;
   localparam logic [11:0] A_DL   = 12'h3E0;

   always #5 clk = ~clk;

   lapic_tmr_top u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tstamp    (tstamp),
      .irq       (irq)
   );

   function automatic logic [63:0] cw(int md, int mk, int dv, int vc);
      return 64'((dv << 19) | (md << 17) | (mk << 16) | vc);
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [63:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1;
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, output logic [63:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic set_ts(logic [63:0] t);
      @(negedge clk);
      tstamp = t;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog act=timeout exp=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] v;
      int t1, t2, t3, seen;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;

      // R1 reset state
      rd(A_CTRL, v); chk("R1 ctrl", v, 64'h10000);
      rd(A_INIT, v); chk("R1 init", v, 0);
      rd(A_CUR, v);  chk("R1 cur", v, 0);
      rd(A_DL, v);   chk("R1 deadline", v, 0);
      chk("R1 irq", irq, 0);

      // R2 field readback and reserved mode code
      wr(A_CTRL, cw(3, 0, 2, 8'h5A));
      rd(A_CTRL, v); chk("R2 rsvd mode keeps one-shot", v, cw(0, 0, 2, 8'h5A));
      wr(A_CTRL, cw(1, 1, 3, 8'hA5));
      rd(A_CTRL, v); chk("R2 readback", v, cw(1, 1, 3, 8'hA5));

      // R3 one-shot sweep, divide 0
      wr(A_CTRL, cw(0, 0, 0, 8'h41));
      for (int n = 2; n <= 6; n++) begin
         wr(A_INIT, 64'(n));
         rd(A_CUR, v); chk("R3 load", v, 64'(n));
         for (int j = 1; j <= n + 4; j++) begin
            step();
            chk("R3 irq timing", irq, (j == n) ? 1'b1 : 1'b0);
            if (j == 1) begin rd(A_CUR, v); chk("R3 decrement", v, 64'(n - 1)); end
         end
         rd(A_CUR, v); chk("R3 held at zero", v, 0);
      end

      // R6 zero initial count stops
      wr(A_INIT, 64'd5);
      step(); step();
      wr(A_INIT, 64'd0);
      seen = 0;
      for (int j = 0; j < 10; j++) begin step(); if (irq) seen++; end
      chk("R6 no irq", 64'(seen), 0);
      rd(A_CUR, v); chk("R6 cur zero", v, 0);

      // R4 R5 periodic interval sweep over divide settings
      for (int d = 0; d <= 3; d++) begin
         for (int n = 1; n <= 5; n++) begin
            wr(A_CTRL, cw(1, 0, d, 0));
            wr(A_INIT, 64'(n));
            t1 = -1; t2 = -1; t3 = -1;
            for (int c = 0; c < 400 && t3 < 0; c++) begin
               step();
               if (irq) begin
                  if (t1 < 0) t1 = c;
                  else if (t2 < 0) t2 = c;
                  else t3 = c;
               end
            end
            chk("R4 R5 period a", 64'(t2 - t1), 64'(n << d));
            chk("R4 R5 period b", 64'(t3 - t2), 64'(n << d));
            wr(A_INIT, 64'd0);
         end
      end

      // R13 periodic -> one-shot keeps count
      wr(A_CTRL, cw(1, 0, 0, 0));
      wr(A_INIT, 64'd10);
      step(); step(); step();
      rd(A_CUR, v); chk("R13 running", v, 64'd7);
      wr(A_CTRL, cw(0, 0, 0, 0));
      rd(A_CUR, v); chk("R13 kept count", v, 64'd6);
      for (int j = 1; j <= 18; j++) begin
         step();
         chk("R13 one-shot after switch", irq, (j == 6) ? 1'b1 : 1'b0);
      end

      // R7 deadline ignored outside deadline mode
      wr(A_DL, 64'd1000);
      rd(A_DL, v); chk("R7 reads zero", v, 0);
      set_ts(64'd5000);
      seen = 0;
      for (int j = 0; j < 4; j++) begin step(); if (irq) seen++; end
      chk("R7 no irq", 64'(seen), 0);

      // R8 entering deadline mode clears counts
      wr(A_INIT, 64'd50);
      wr(A_CTRL, cw(2, 0, 0, 0));
      rd(A_INIT, v); chk("R8 init cleared", v, 0);
      rd(A_CUR, v);  chk("R8 cur cleared", v, 0);
      wr(A_INIT, 64'd77);
      rd(A_INIT, v); chk("R8 init write ignored", v, 0);
      rd(A_CUR, v);  chk("R8 cur stays zero", v, 0);

      // R9 arm and fire
      set_ts(64'd500);
      wr(A_DL, 64'd1000);
      rd(A_DL, v); chk("R9 readback", v, 64'd1000);
      step(); chk("R9 no early irq", irq, 0);
      set_ts(64'd999);
      step(); chk("R9 below deadline", irq, 0);
      set_ts(64'd1000);
      step(); chk("R9 fires at equal", irq, 1);
      rd(A_DL, v); chk("R9 cleared", v, 0);
      step(); chk("R9 single pulse", irq, 0);
      wr(A_DL, 64'd300);
      rd(A_DL, v); chk("R9 past deadline held", v, 64'd300);
      chk("R9 write beats fire", irq, 0);
      step(); chk("R9 past deadline fires", irq, 1);
      step(); chk("R9 past single pulse", irq, 0);

      // R10 zero disarms
      set_ts(64'd0);
      wr(A_DL, 64'd5000);
      wr(A_DL, 64'd0);
      rd(A_DL, v); chk("R10 disarmed", v, 0);
      set_ts(64'd9999);
      seen = 0;
      for (int j = 0; j < 4; j++) begin step(); if (irq) seen++; end
      chk("R10 no irq", 64'(seen), 0);

      // R12 mask on deadline
      set_ts(64'd0);
      wr(A_DL, 64'd400);
      wr(A_CTRL, cw(2, 1, 0, 0));
      rd(A_DL, v); chk("R12 armed across mask write", v, 64'd400);
      set_ts(64'd500);
      seen = 0;
      for (int j = 0; j < 4; j++) begin step(); if (irq) seen++; end
      chk("R12 masked deadline no irq", 64'(seen), 0);
      rd(A_DL, v); chk("R12 deadline consumed", v, 0);

      // R11 leaving deadline mode clears deadline
      set_ts(64'd0);
      wr(A_CTRL, cw(2, 0, 0, 0));
      wr(A_DL, 64'd700);
      wr(A_CTRL, cw(0, 0, 0, 0));
      rd(A_DL, v); chk("R11 cleared on leave", v, 0);
      wr(A_CTRL, cw(2, 0, 0, 0));
      rd(A_DL, v); chk("R11 not restored", v, 0);
      set_ts(64'd800);
      seen = 0;
      for (int j = 0; j < 4; j++) begin step(); if (irq) seen++; end
      chk("R11 no irq", 64'(seen), 0);

      // R12 mask on countdown
      wr(A_CTRL, cw(0, 1, 0, 0));
      wr(A_INIT, 64'd3);
      seen = 0;
      for (int j = 0; j < 8; j++) begin step(); if (irq) seen++; end
      chk("R12 masked count no irq", 64'(seen), 0);
      rd(A_CUR, v); chk("R12 count ran out", v, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule